// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles the outcome of a conditional relative branch in a small 8-bit style processor. A 2-bit field picks one of four status flags. A compare bit gives the flag value that causes the jump. The branch is taken when the picked flag equals the compare bit, so each flag can serve both the "set" and the "clear" sense of a branch. Branch-on-not-equal, for example, picks the zero flag with a compare value of 0.

When the condition fails, the 8-bit displacement is forced to zero. The result is then sign-extended and fed to one shared 16-bit adder together with the current program counter. The program counter input is expected to already point past the branch, so the displacement is measured from the next instruction. The instruction code is never rewritten to steer control flow; only the qualified condition separates the two outcomes.

The surrounding sequencer appears only as a load strobe. The new program counter is captured on a clock edge while the strobe is high. The taken indication is combinational and follows the strobe in the same cycle.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is applied, and after it is released, until the first load, `pc_out` reads 0x0000 and `taken` reads 0.
- R2: `cond_sel` picks the tested flag with this encoding: 2'b00 negative, 2'b01 overflow, 2'b10 carry, 2'b11 zero. The condition holds when the picked flag equals `cond_val`.
- R3: `taken` is 1 exactly when `load_en` is 1 and the condition holds, in that same cycle; it is 0 whenever `load_en` is 0.
- R4: On a clock edge with `load_en` = 1 and a failed condition, `pc_out` becomes `pc_in` unchanged, whatever the displacement.
- R5: On a clock edge with `load_en` = 1 and a met condition, `pc_out` becomes `pc_in` plus the displacement read as an 8-bit two's-complement value, sign-extended from bit 7.
- R6: Displacement 0x80 moves the counter by -128 and 0x7F moves it by +127 when taken; both leave it unchanged when not taken.
- R7: The sum wraps modulo 2^16 in both directions (for example 0xFFF0 + 0x20 gives 0x0010, and 0x0005 + 0xF0 gives 0xFFF5).
- R8: On a clock edge with `load_en` = 0, `pc_out` keeps its value, whatever the other inputs are.
- R9: Flags that `cond_sel` does not pick have no effect on `taken` or on the loaded `pc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cond_sel | input | 2 | Selects the tested flag (00 N, 01 V, 10 C, 11 Z) |
| cond_val | input | 1 | Flag value that makes the branch taken |
| flag_n | input | 1 | Negative status flag |
| flag_v | input | 1 | Overflow status flag |
| flag_c | input | 1 | Carry status flag |
| flag_z | input | 1 | Zero status flag |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Program counter of the instruction after the branch |
| load_en | input | 1 | Sequencer strobe that captures the new counter |
| pc_out | output | 16 | Registered resolved program counter |
| taken | output | 1 | Branch-taken indication, valid while `load_en` is high |

## Verification
The assertions assume that `pc_in`, `disp`, the flags and the select inputs are stable and known around each rising edge. They also assume that the sequencer raises `load_en` only after the internal reset release has completed. The bench changes every input just after the falling edge. It waits several cycles after reset release before the first strobe, so each strobed edge sees settled values. The stimulus walks every select code with both compare values, toggles the flags that are not picked, and places the extreme displacements next to the top and bottom of the address space.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int unsigned PC_W  = 16;
  localparam int unsigned OFF_W = 8;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_NEG = 2'b00,
    SEL_OVF = 2'b01,
    SEL_CRY = 2'b10,
    SEL_ZER = 2'b11
  } cond_sel_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic cry;
    logic zer;
  } status_t;
endpackage

// File: rtl/rbu_rst_sync.sv
module rbu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
  import rbu_pkg::*;
(
  input  status_t          flags,
  input  logic [SEL_W-1:0] sel,
  input  logic             cmp,
  output logic             cond_ok
);
  logic picked;

  always_comb begin
    unique case (cond_sel_e'(sel))
      SEL_NEG: picked = flags.neg;
      SEL_OVF: picked = flags.ovf;
      SEL_CRY: picked = flags.cry;
      SEL_ZER: picked = flags.zer;
      default: picked = 1'b0;
    endcase
    cond_ok = ~(picked ^ cmp);
  end
endmodule

// File: rtl/rbu_disp_gate.sv
module rbu_disp_gate #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  disp,
  input  logic             keep,
  output logic [OUT_W-1:0] ext
);
  localparam int unsigned PAD_W = OUT_W - IN_W;
  logic [IN_W-1:0] masked;

  always_comb begin
    masked = disp & {IN_W{keep}};
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign ext = {{PAD_W{masked[IN_W-1]}}, masked};
    end else begin : g_nopad
      assign ext = masked[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rbu_adder.sv
module rbu_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  always_comb begin
    sum = a + b;
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             cond_val,
  input  logic             flag_n,
  input  logic             flag_v,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic [OFF_W-1:0] disp,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             load_en,
  output logic [PC_W-1:0]  pc_out,
  output logic             taken
);
  logic            rst_q_n;
  status_t         flags;
  logic            cond_ok;
  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] pc_sum;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] pc_q;

  rbu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  always_comb begin
    flags.neg = flag_n;
    flags.ovf = flag_v;
    flags.cry = flag_c;
    flags.zer = flag_z;
  end

  rbu_cond_eval u_cond (
    .flags(flags), .sel(cond_sel), .cmp(cond_val), .cond_ok(cond_ok)
  );

  rbu_disp_gate #(.IN_W(OFF_W), .OUT_W(PC_W)) u_gate (
    .disp(disp), .keep(cond_ok), .ext(disp_ext)
  );

  rbu_adder #(.W(PC_W)) u_add (
    .a(pc_in), .b(disp_ext), .sum(pc_sum)
  );

  always_comb begin
    pc_d = load_en ? pc_sum : pc_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pc_q <= '0;
    else          pc_q <= pc_d;
  end

  assign pc_out = pc_q;
  assign taken  = load_en & cond_ok;
endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk
  import rbu_pkg::*;
(
  input logic             clk,
  input logic             rst_q_n,
  input logic [SEL_W-1:0] cond_sel,
  input logic             cond_val,
  input logic             flag_z,
  input logic [OFF_W-1:0] disp,
  input logic [PC_W-1:0]  pc_in,
  input logic             load_en,
  input logic [PC_W-1:0]  pc_out,
  input logic             taken
);
  // R3
  idle_no_taken_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load_en |-> !taken);

  // R8
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load_en |=> $stable(pc_out));

  // R4
  not_taken_pc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load_en && !taken) |=> pc_out == $past(pc_in));

  // R5
  taken_pc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load_en && taken) |=>
      pc_out == PC_W'($past(pc_in) + {{(PC_W-OFF_W){$past(disp[OFF_W-1])}}, $past(disp)}));

  // R2
  zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load_en && cond_sel == 2'b11) |-> taken == (flag_z == cond_val));
endmodule

bind rel_branch_unit rel_branch_unit_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .cond_sel(cond_sel), .cond_val(cond_val),
  .flag_z(flag_z), .disp(disp), .pc_in(pc_in), .load_en(load_en),
  .pc_out(pc_out), .taken(taken)
);

// File: tb/rel_branch_unit_tb.sv
`timescale 1ns/1ps
module rel_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cond_sel;
  logic        cond_val;
  logic        flag_n, flag_v, flag_c, flag_z;
  logic [7:0]  disp;
  logic [15:0] pc_in;
  logic        load_en;
  logic [15:0] pc_out;
  logic        taken;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] model_pc;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rel_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .cond_val(cond_val),
    .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
    .disp(disp), .pc_in(pc_in), .load_en(load_en), .pc_out(pc_out), .taken(taken)
  );

  function automatic logic pick(input logic [1:0] s, input logic [3:0] f);
    // f = {n, v, c, z}; R2 encoding
    case (s)
      2'b00: return f[3];
      2'b01: return f[2];
      2'b10: return f[1];
      default: return f[0];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one strobe cycle, checks taken, queues expected pc
  task automatic drive(input string req, input logic ld, input logic [1:0] s,
                       input logic cv, input logic [3:0] f,
                       input logic [7:0] d, input logic [15:0] pc);
    logic c;
    @(negedge clk);
    load_en = ld; cond_sel = s; cond_val = cv;
    {flag_n, flag_v, flag_c, flag_z} = f;
    disp = d; pc_in = pc;
    c = (pick(s, f) == cv);
    #1;
    check({req, " taken"}, {15'd0, taken}, {15'd0, ld & c});
    if (ld) model_pc = c ? 16'(pc + {{8{d[7]}}, d}) : pc;
    exp_q.push_back(model_pc);
    tag_q.push_back(req);
  endtask

  // monitor: compares the registered pc one falling edge later
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " pc"}, pc_out, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_en = 0; cond_sel = 0; cond_val = 0;
    {flag_n, flag_v, flag_c, flag_z} = 4'b0; disp = 0; pc_in = 0;
    model_pc = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc_out, 16'h0000);
    check("R1 reset taken", {15'd0, taken}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", pc_out, 16'h0000);

    // R2: each select, both compare senses
    for (int s = 0; s < 4; s++) begin
      for (int cv = 0; cv < 2; cv++) begin
        drive("R2 sel only set", 1, 2'(s), 1'(cv), 4'b1000 >> s, 8'h10, 16'h2000);
        drive("R2 sel all clear", 1, 2'(s), 1'(cv), 4'b0000, 8'h04, 16'h3000);
      end
    end
    // R9: unselected flags toggled, picked flag fixed
    drive("R9 others set", 1, 2'b11, 1'b0, 4'b1110, 8'h08, 16'h4000);
    drive("R9 others set nt", 1, 2'b11, 1'b1, 4'b1110, 8'h08, 16'h4000);
    drive("R9 carry others", 1, 2'b10, 1'b1, 4'b1011, 8'hF8, 16'h5000);
    // R3 / R8: strobe low holds pc and keeps taken low
    drive("R8 hold", 0, 2'b11, 1'b0, 4'b0000, 8'h40, 16'h1234);
    drive("R3 idle", 0, 2'b00, 1'b1, 4'b1000, 8'h7F, 16'hAAAA);
    // R4 / R5 basics
    drive("R5 forward", 1, 2'b01, 1'b1, 4'b0100, 8'h22, 16'h0800);
    drive("R5 backward", 1, 2'b01, 1'b1, 4'b0100, 8'hFE, 16'h0800);
    drive("R4 not taken", 1, 2'b01, 1'b0, 4'b0100, 8'h22, 16'h0800);
    // R6 extremes, taken and not taken
    drive("R6 0x80 taken", 1, 2'b00, 1'b1, 4'b1000, 8'h80, 16'h1000);
    drive("R6 0x80 nt", 1, 2'b00, 1'b0, 4'b1000, 8'h80, 16'h1000);
    drive("R6 0x7F taken", 1, 2'b00, 1'b1, 4'b1000, 8'h7F, 16'h1000);
    drive("R6 0x7F nt", 1, 2'b00, 1'b0, 4'b1000, 8'h7F, 16'h1000);
    // R7 wrap both ways, taken and not taken
    drive("R7 wrap up", 1, 2'b10, 1'b1, 4'b0010, 8'h20, 16'hFFF0);
    drive("R7 wrap up nt", 1, 2'b10, 1'b0, 4'b0010, 8'h20, 16'hFFF0);
    drive("R7 wrap down", 1, 2'b10, 1'b1, 4'b0010, 8'hF0, 16'h0005);
    drive("R7 wrap down nt", 1, 2'b10, 1'b0, 4'b0010, 8'hF0, 16'h0005);
    drive("R7 wrap 7F", 1, 2'b11, 1'b1, 4'b0001, 8'h7F, 16'hFFC0);
    drive("R7 wrap 80", 1, 2'b11, 1'b1, 4'b0001, 8'h80, 16'h0010);
    drive("R8 hold end", 0, 2'b11, 1'b1, 4'b0001, 8'h55, 16'h7777);

    @(negedge clk);
    load_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule